// File: doc/BRIEF.md
# Clause-22 MDIO Management Controller

This block lets a host processor talk to Ethernet PHYs over a two-wire management bus. The host programs six word registers: configuration, command, address, write data, read data and indicators. The controller then runs one complete clause-22 frame on its own. It derives the management clock (MDC) from the system clock through a programmable divisor. It shifts out the 32-bit preamble, the start and opcode fields, the PHY and register addresses, the turnaround and the data field. On a read, it releases the data line and collects the 16 bits that the PHY returns.

A write frame starts when the host stores a value in the write-data register. It is sent to the PHY and register held in the address register. A read frame starts when bit 0 of the command register changes from 0 to 1. Writing 1 over a bit that is already 1 starts nothing, so the host clears the bit between reads. While a frame is running, the busy indicator is set and host writes to the command, address and write-data registers are dropped. The configuration register carries a soft reset that aborts any frame and holds the bus idle while it is set.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, every register reads as zero, MDC is low and the MDIO output enable is low.
- R2: The address register (select 2) keeps a 5-bit PHY address in bits 12:8 and a 5-bit register number in bits 4:0. All other bits read as zero.
- R3: A write to the write-data register (select 3) when idle sends this frame, MSB first: 32 ones, 01, opcode 01, PHY address, register number, turnaround 10, then the 16 data bits. MDIO is driven for the whole frame.
- R4: A read frame sends the same header with opcode 10. MDIO is released for the 2 turnaround bits and the 16 data bits. The data bits are sampled just before each MDC rising edge, MSB first, and appear in bits 15:0 of the read-data register (select 4) once the frame ends.
- R5: A read starts only when bit 0 of the command register (select 1) goes from 0 to 1. Writing 1 while the stored bit is already 1 starts no frame.
- R6: Indicator bit 0 (select 5) is set from the cycle after a launch and stays set for exactly 128×(N+1) cycles.
- R7: With divisor code N in the low 4 bits of the configuration register (select 0), MDC has a period of 2×(N+1) system clocks. MDC stays low while no frame runs.
- R8: While busy is set, writes to the command, address and write-data registers are ignored. They change no stored value and start no frame.
- R9: Indicator bit 2 is set when a read frame completes. It is cleared by the next accepted write to the command register.
- R10: Bit 31 of the configuration register is a soft reset. While it is 1, any running frame is aborted, busy and the invalid flag read 0, MDC is low, MDIO is released and no frame can start. After it is cleared, frames run normally.
- R11: The MDIO output changes only on MDC falling transitions and stays stable while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe for one cycle |
| reg_sel | input | 3 | Word select of the register being accessed |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read-back of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_out | output | 1 | Serial data driven toward the PHYs |
| mdio_oe | output | 1 | High while the controller drives MDIO |
| mdio_in | input | 1 | Serial data returned by a PHY |

## Verification
The assertions assume that the host changes the divisor only while no frame is running. They also assume that `reg_sel` and `reg_wdata` are valid whenever `reg_wr` is high. The bench changes the divisor only after polling busy low. It holds every host write for a single cycle with stable select and data. Its PHY responder changes `mdio_in` only after a falling MDC edge, so each sampled bit has been stable for a full half period.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int unsigned FRAME_LEN = 64;
    localparam int unsigned PRE_LEN   = 32;
    localparam int unsigned TA_IDX    = 46;
    localparam int unsigned DATA_IDX  = 48;
    localparam int unsigned DATA_W    = 16;
    localparam int unsigned FIELD_W   = 5;
    localparam int unsigned BIT_CNT_W = $clog2(FRAME_LEN);

    localparam logic [2:0] SEL_CFG  = 3'd0;
    localparam logic [2:0] SEL_CMD  = 3'd1;
    localparam logic [2:0] SEL_ADR  = 3'd2;
    localparam logic [2:0] SEL_WDAT = 3'd3;
    localparam logic [2:0] SEL_RDAT = 3'd4;
    localparam logic [2:0] SEL_IND  = 3'd5;

    localparam int unsigned CFG_RST_BIT   = 31;
    localparam int unsigned CMD_GO_BIT    = 0;
    localparam int unsigned IND_BUSY_BIT  = 0;
    localparam int unsigned IND_INVAL_BIT = 2;
    localparam int unsigned ADR_PHY_LSB   = 8;
    localparam int unsigned ADR_REG_LSB   = 0;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e            op;
        logic [FIELD_W-1:0]  phy;
        logic [FIELD_W-1:0]  regn;
        logic [DATA_W-1:0]   wdat;
    } mdio_req_t;

    // Whole serial frame, first bit on the wire in the MSB.
    function automatic logic [FRAME_LEN-1:0] frame_word(input mdio_req_t r);
        logic [1:0]        ta;
        logic [DATA_W-1:0] pay;
        ta  = (r.op == OP_WRITE) ? 2'b10  : 2'b11;
        pay = (r.op == OP_WRITE) ? r.wdat : '1;
        return {{PRE_LEN{1'b1}}, 2'b01, r.op, r.phy, r.regn, ta, pay};
    endfunction

endpackage

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_mgmt_pkg::*;
#(
    parameter int unsigned DIV_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [2:0]          host_sel,
    input  logic [31:0]         host_wdata,
    output logic [31:0]         host_rdata,
    input  logic                busy,
    input  logic                rd_done,
    input  logic [DATA_W-1:0]   rd_word,
    output logic                soft_rst,
    output logic [DIV_W-1:0]    div,
    output logic                launch,
    output mdio_req_t           launch_req
);

    logic                 cfg_rst_q;
    logic [DIV_W-1:0]     div_q;
    logic                 go_q;
    logic [FIELD_W-1:0]   phy_q;
    logic [FIELD_W-1:0]   regn_q;
    logic [DATA_W-1:0]    wdat_q;
    logic [DATA_W-1:0]    rdat_q;
    logic                 inval_q;

    logic accept;
    logic launch_rd;
    logic launch_wr;

    always_comb begin
        accept    = host_wr && !busy;
        launch_rd = accept && (host_sel == SEL_CMD) && host_wdata[CMD_GO_BIT]
                    && !go_q && !cfg_rst_q;
        launch_wr = accept && (host_sel == SEL_WDAT) && !cfg_rst_q;
        launch    = launch_rd || launch_wr;
        launch_req.op   = launch_wr ? OP_WRITE : OP_READ;
        launch_req.phy  = phy_q;
        launch_req.regn = regn_q;
        launch_req.wdat = host_wdata[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rst_q <= 1'b0;
            div_q     <= '0;
            go_q      <= 1'b0;
            phy_q     <= '0;
            regn_q    <= '0;
            wdat_q    <= '0;
            rdat_q    <= '0;
            inval_q   <= 1'b0;
        end else begin
            if (host_wr && host_sel == SEL_CFG) begin
                cfg_rst_q <= host_wdata[CFG_RST_BIT];
                div_q     <= host_wdata[DIV_W-1:0];
            end
            if (accept && host_sel == SEL_CMD) begin
                go_q    <= host_wdata[CMD_GO_BIT];
                inval_q <= 1'b0;
            end
            if (accept && host_sel == SEL_ADR) begin
                phy_q  <= host_wdata[ADR_PHY_LSB +: FIELD_W];
                regn_q <= host_wdata[ADR_REG_LSB +: FIELD_W];
            end
            if (accept && host_sel == SEL_WDAT) begin
                wdat_q <= host_wdata[DATA_W-1:0];
            end
            if (rd_done) begin
                rdat_q  <= rd_word;
                inval_q <= 1'b1;
            end
            if (cfg_rst_q) begin
                inval_q <= 1'b0;
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_sel)
            SEL_CFG: begin
                host_rdata[CFG_RST_BIT] = cfg_rst_q;
                host_rdata[DIV_W-1:0]   = div_q;
            end
            SEL_CMD:  host_rdata[CMD_GO_BIT] = go_q;
            SEL_ADR: begin
                host_rdata[ADR_PHY_LSB +: FIELD_W] = phy_q;
                host_rdata[ADR_REG_LSB +: FIELD_W] = regn_q;
            end
            SEL_WDAT: host_rdata[DATA_W-1:0] = wdat_q;
            SEL_RDAT: host_rdata[DATA_W-1:0] = rdat_q;
            SEL_IND: begin
                host_rdata[IND_BUSY_BIT]  = busy;
                host_rdata[IND_INVAL_BIT] = inval_q;
            end
            default: host_rdata = '0;
        endcase
    end

    assign soft_rst = cfg_rst_q;
    assign div      = div_q;

    // R8
    busy_adr_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && host_wr && host_sel == SEL_ADR) |=> ($stable(phy_q) && $stable(regn_q)));

    // R9
    inval_from_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(inval_q) |-> $past(rd_done));

    // R10
    soft_rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rst_q |=> !busy);

endmodule

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             tick;

    always_comb begin
        tick     = run && (cnt_q >= div);
        rise_stb = tick && !mdc_q;
        fall_stb = tick && mdc_q;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= !mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc = mdc_q;

    // R7
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc_q);

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise_stb, fall_stb}));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  mdio_req_t          req,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdc,
    input  logic               mdio_in,
    output logic               active,
    output logic               mdio_out,
    output logic               mdio_oe,
    output logic               rd_done,
    output logic [DATA_W-1:0]  rd_word
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_LEN - 1);
    localparam logic [BIT_CNT_W-1:0] TA_BIT   = BIT_CNT_W'(TA_IDX);
    localparam logic [BIT_CNT_W-1:0] DAT_BIT  = BIT_CNT_W'(DATA_IDX);

    logic [FRAME_LEN-1:0] shreg_q;
    logic [BIT_CNT_W-1:0] bitcnt_q;
    logic                 active_q;
    logic                 is_rd_q;
    logic [DATA_W-1:0]    rdsh_q;
    logic                 last;

    assign last = active_q && fall_stb && (bitcnt_q == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q  <= '0;
            bitcnt_q <= '0;
            active_q <= 1'b0;
            is_rd_q  <= 1'b0;
            rdsh_q   <= '0;
        end else if (start && !active_q) begin
            shreg_q  <= frame_word(req);
            bitcnt_q <= '0;
            active_q <= 1'b1;
            is_rd_q  <= (req.op == OP_READ);
        end else if (active_q) begin
            if (rise_stb && is_rd_q && bitcnt_q >= DAT_BIT) begin
                rdsh_q <= {rdsh_q[DATA_W-2:0], mdio_in};
            end
            if (fall_stb) begin
                if (bitcnt_q == LAST_BIT) begin
                    active_q <= 1'b0;
                end else begin
                    shreg_q  <= {shreg_q[FRAME_LEN-2:0], 1'b1};
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        active   = active_q;
        mdio_out = shreg_q[FRAME_LEN-1];
        mdio_oe  = active_q && (!is_rd_q || bitcnt_q < TA_BIT);
        rd_done  = last && is_rd_q;
        rd_word  = rdsh_q;
    end

    // R11
    mdo_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(shreg_q[FRAME_LEN-1]));

    // R6
    start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !active_q);

    // R4
    release_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rise_stb && is_rd_q && bitcnt_q >= DAT_BIT) |-> !mdio_oe);

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int unsigned DIV_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);

    logic              soft_rst;
    logic              eng_rst;
    logic [DIV_W-1:0]  div;
    logic              launch;
    mdio_req_t         launch_req;
    logic              busy;
    logic              rd_done;
    logic [DATA_W-1:0] rd_word;
    logic              rise_stb;
    logic              fall_stb;

    assign eng_rst = rst || soft_rst;

    mdio_reg_bank #(.DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (reg_wr),
        .host_sel   (reg_sel),
        .host_wdata (reg_wdata),
        .host_rdata (reg_rdata),
        .busy       (busy),
        .rd_done    (rd_done),
        .rd_word    (rd_word),
        .soft_rst   (soft_rst),
        .div        (div),
        .launch     (launch),
        .launch_req (launch_req)
    );

    mdio_clk_div #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst      (eng_rst),
        .run      (busy),
        .div      (div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst      (eng_rst),
        .start    (launch),
        .req      (launch_req),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdc      (mdc),
        .mdio_in  (mdio_in),
        .active   (busy),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done),
        .rd_word  (rd_word)
    );

endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module test_mdio_mgmt_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in = 1'b1;

    always #2 clk = ~clk;

    mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    typedef struct {
        bit drv;
        bit val;
        int req;
    } exp_bit_t;

    exp_bit_t    exp_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    longint      cyc = 0;
    longint      last_rise = -1;
    int          exp_period = 2;
    int          rises = 0;
    logic [15:0] resp = '0;
    bit          mon_en = 1'b1;
    logic        mdc_prev = 1'b0;
    logic        mdo_prev = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops expected wire bits at each MDC rise and plays the PHY.
    always @(negedge clk) begin : monitor
        exp_bit_t e;
        if (mon_en) begin
            if (mdc && !mdc_prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected MDC rise", 32'd1, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    if (e.drv)
                        chk(mdio_oe === 1'b1 && mdio_out === e.val,
                            $sformatf("R%0d frame bit %0d (oe,data)", e.req, rises),
                            {30'd0, mdio_oe, mdio_out}, {30'd0, 1'b1, e.val});
                    else
                        chk(mdio_oe === 1'b0,
                            $sformatf("R4 released bit %0d oe", rises),
                            {31'd0, mdio_oe}, 32'd0);
                end
                if (last_rise >= 0)
                    chk(cyc - last_rise == longint'(exp_period), "R7 MDC period",
                        32'(cyc - last_rise), 32'(exp_period));
                last_rise = cyc;
                rises++;
            end
            if (mdc && mdc_prev)
                chk(mdio_out === mdo_prev, "R11 MDIO moved while MDC high",
                    {31'd0, mdio_out}, {31'd0, mdo_prev});
            if (!mdc && mdc_prev)
                mdio_in = (rises >= 48 && rises < 64) ? resp[63 - rises] : 1'b1;
        end
        mdc_prev = mdc;
        mdo_prev = mdio_out;
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_sel   = sel;
        reg_wdata = data;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] val);
        reg_sel = sel;
        #0.5;
        val = reg_rdata;
    endtask

    // Driver: queue the 64 wire bits expected for one frame.
    task automatic push_frame(input bit is_rd, input logic [4:0] phy,
                              input logic [4:0] regn, input logic [15:0] data,
                              input int div, input int req);
        exp_period = 2 * (div + 1);
        last_rise  = -1;
        rises      = 0;
        for (int i = 0; i < 64; i++) begin
            exp_bit_t e;
            e.drv = 1'b1;
            e.req = req;
            if (i < 32)      e.val = 1'b1;
            else if (i == 32) e.val = 1'b0;
            else if (i == 33) e.val = 1'b1;
            else if (i == 34) e.val = is_rd;
            else if (i == 35) e.val = !is_rd;
            else if (i < 41) e.val = phy[40 - i];
            else if (i < 46) e.val = regn[45 - i];
            else if (is_rd) begin
                e.drv = 1'b0;
                e.val = 1'b0;
            end else if (i == 46) e.val = 1'b1;
            else if (i == 47) e.val = 1'b0;
            else e.val = data[63 - i];
            exp_q.push_back(e);
        end
    endtask

    task automatic wait_idle(input int exp_len, input string tag);
        logic [31:0] v;
        int n;
        n = 0;
        for (int k = 0; k < 5000; k++) begin
            rd(3'd5, v);
            if (!v[0]) break;
            n++;
            @(negedge clk);
        end
        if (exp_len >= 0) chk(n == exp_len, tag, 32'(n), 32'(exp_len));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R6 watchdog expired, frame never finished");
        report();
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int s = 0; s < 6; s++) begin
            rd(3'(s), v);
            chk(v == 32'd0, $sformatf("R1 register %0d after reset", s), v, 32'd0);
        end
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1 MDC/oe idle", {30'd0, mdc, mdio_oe}, 32'd0);

        // R2 address field layout
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v);
        chk(v == 32'h0000_1F1F, "R2 address readback", v, 32'h1F1F);

        // R3 write frame, divisor 0
        wr(3'd0, 32'd0);
        wr(3'd2, {19'd0, 5'h05, 3'd0, 5'h1A});
        push_frame(1'b0, 5'h05, 5'h1A, 16'hA55A, 0, 3);
        wr(3'd3, 32'h0000_A55A);
        wait_idle(128, "R6 busy length div0");
        chk(exp_q.size() == 0, "R3 all write bits seen", 32'(exp_q.size()), 32'd0);

        // R4 read frame, divisor 2
        wr(3'd0, 32'd2);
        wr(3'd2, {19'd0, 5'h11, 3'd0, 5'h03});
        resp = 16'hC3E1;
        push_frame(1'b1, 5'h11, 5'h03, 16'h0, 2, 4);
        wr(3'd1, 32'd1);
        wait_idle(384, "R6 busy length div2");
        chk(exp_q.size() == 0, "R4 all read bits seen", 32'(exp_q.size()), 32'd0);
        rd(3'd4, v);
        chk(v == 32'h0000_C3E1, "R4 read data", v, 32'hC3E1);
        rd(3'd5, v);
        chk(v == 32'h4, "R9 invalid set after read", v, 32'h4);

        // R5 command bit already 1: no frame; R9 invalid cleared
        wr(3'd1, 32'd1);
        repeat (20) @(negedge clk);
        rd(3'd5, v);
        chk(v == 32'h0, "R5 no read without 0 first / R9 cleared", v, 32'h0);

        // R8 writes during busy are dropped
        wr(3'd1, 32'd0);
        wr(3'd2, {19'd0, 5'h1F, 3'd0, 5'h1F});
        resp = 16'h1234;
        push_frame(1'b1, 5'h1F, 5'h1F, 16'h0, 2, 4);
        wr(3'd1, 32'd1);
        wr(3'd2, 32'h0000_0203);
        wr(3'd3, 32'h0000_FFFF);
        wr(3'd1, 32'd0);
        wait_idle(-1, "R8");
        rd(3'd4, v);
        chk(v == 32'h0000_1234, "R4 second read data", v, 32'h1234);
        rd(3'd2, v);
        chk(v == 32'h0000_1F1F, "R8 address kept", v, 32'h1F1F);
        rd(3'd1, v);
        chk(v == 32'h1, "R8 command kept", v, 32'h1);
        rd(3'd3, v);
        chk(v == 32'h0000_A55A, "R8 write data kept", v, 32'hA55A);
        repeat (10) @(negedge clk);
        rd(3'd5, v);
        chk(v == 32'h4, "R8 no extra frame", v, 32'h4);
        chk(exp_q.size() == 0, "R8 queue drained", 32'(exp_q.size()), 32'd0);

        // R7 divisor 5
        wr(3'd0, 32'd5);
        wr(3'd2, {19'd0, 5'h0A, 3'd0, 5'h15});
        push_frame(1'b0, 5'h0A, 5'h15, 16'h0F0F, 5, 3);
        wr(3'd3, 32'h0000_0F0F);
        wait_idle(768, "R6 busy length div5");
        chk(exp_q.size() == 0, "R7 all bits seen div5", 32'(exp_q.size()), 32'd0);

        // R10 soft reset mid-frame
        wr(3'd0, 32'd1);
        mon_en = 1'b0;
        wr(3'd3, 32'h0000_1357);
        repeat (50) @(negedge clk);
        wr(3'd0, 32'h8000_0001);
        @(negedge clk);
        rd(3'd5, v);
        chk(v == 32'h0, "R10 busy/invalid cleared", v, 32'h0);
        chk(mdc === 1'b0 && mdio_oe === 1'b0, "R10 bus idle", {30'd0, mdc, mdio_oe}, 32'd0);
        wr(3'd3, 32'h0000_2468);
        repeat (10) @(negedge clk);
        rd(3'd5, v);
        chk(v == 32'h0 && mdc === 1'b0, "R10 no launch in reset", v, 32'h0);
        rd(3'd0, v);
        chk(v == 32'h8000_0001, "R10 config readback", v, 32'h8000_0001);
        wr(3'd0, 32'd1);
        exp_q.delete();
        mon_en = 1'b1;
        push_frame(1'b0, 5'h0A, 5'h15, 16'h0ACE, 1, 10);
        wr(3'd3, 32'h0000_0ACE);
        wait_idle(256, "R10 frame after release");
        chk(exp_q.size() == 0, "R10 all bits seen", 32'(exp_q.size()), 32'd0);

        repeat (5) @(negedge clk);
        report();
        $finish;
    end

endmodule